// File: doc/BRIEF.md
# Memory Management Fault Status Capture

This block records why and where the most recent memory translation fault happened. On every fault strobe, it builds a status word from the translation mode in effect, the kind of access, the processor privilege state and the cause bits raised by the fault-detection logic. It stores that word and the faulting virtual address in two registers that software can read.

A misaligned-access strobe also captures a fault. It records the address and sets a cause flag of its own. The block remembers whether software has seen the previous fault. If a new fault arrives first, it raises an overflow flag and merges the cause bits instead of replacing them. A software read of the status word clears the valid and overflow flags.

The block does not detect faults and does not deliver traps. It only holds the record that a trap handler reads.

Top module: `mmu_fault_capture`

## Requirements
- R1: After reset, `statusWord` and `faultAddr` are all zeros.
- R2: A capture is a cycle in which `faultStb` or `misalignStb` is high. After each capture, the valid bit (status bit 0) is 1 and `faultAddr` holds the `faultAddrIn` value from the capture cycle. Both outputs change one clock after the capture cycle.
- R3: A capture in a cycle where the valid bit is already 1 and `statusRd` is low sets the overflow bit (status bit 1).
- R4: A `statusRd` cycle without a capture clears the valid and overflow bits on the next clock. All other status fields and `faultAddr` keep their values.
- R5: When a capture and `statusRd` happen in the same cycle, the new fault wins. Valid becomes 1, overflow becomes 0, and the cause fields are replaced rather than merged.
- R6: Status bits 3:2 hold the context type. `xlatMode` is decoded as follows: 0 (untranslated) gives 00. Codes 1 and 2 (user or kernel primary) give 01. Codes 3 and 4 (user or kernel secondary) give 10. Code 5 (nucleus) gives 11. The reserved codes 6 and 7 give 00.
- R7: An instruction fetch (`accType` = 3) captured while `trapLevelNz` is 1 records context type 11, whatever the value of `xlatMode`.
- R8: `accType` is decoded as 0 load, 1 store, 2 non-faulting load, 3 fetch. A store sets the write bit (status bit 4). A non-faulting load sets the no-fault bit (status bit 5). Every other access type clears both bits.
- R9: Status bit 6 records `privState` from the capture cycle.
- R10: The cause field occupies status bits 8 upward, `FT_W` bits wide. The misaligned flag is status bit 7. The `faultBits` input contributes only when `faultStb` is high, and the misaligned flag is set only when `misalignStb` is high. When the valid bit is clear, or a read coincides with the capture, these bits replace the old ones. Otherwise they are ORed into the old ones.
- R11: `misalignStb` on its own captures a fault with the misaligned flag set and the cause field zero, apart from any merged bits.
- R12: In a cycle with no capture and no read, `statusWord` and `faultAddr` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| faultStb | input | 1 | Translation fault detected this cycle |
| misalignStb | input | 1 | Misaligned-access fault this cycle |
| statusRd | input | 1 | Software read of the status word |
| xlatMode | input | 3 | Translation mode of the faulting access |
| accType | input | 2 | 0 load, 1 store, 2 non-faulting load, 3 fetch |
| privState | input | 1 | Processor in privileged state |
| trapLevelNz | input | 1 | Trap level above zero |
| faultBits | input | FT_W | Cause bits from the detection logic |
| faultAddrIn | input | ADDR_W | Virtual address of the faulting access |
| statusWord | output | 8+FT_W | Fault status register |
| faultAddr | output | ADDR_W | Fault address register |

## Verification
The stored valid flag decides whether a capture replaces the cause bits or merges into them, and whether overflow rises. A valid flag that is stuck or cleared at the wrong time therefore shows up on `statusWord` one clock after the next capture: the overflow bit is wrong, or old cause bits remain or vanish.

The bench mixes long random runs with directed cases: back-to-back faults, a read that coincides with a capture, a fetch while the trap level is raised, and a misaligned strobe on its own. Any such error reaches the ports within one or two vectors.

// File: rtl/mfc_pkg.sv
package mfc_pkg;

  // Access type encodings
  localparam logic [1:0] ACC_LOAD  = 2'd0;
  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_NFLD  = 2'd2;
  localparam logic [1:0] ACC_FETCH = 2'd3;

  // Translation mode encodings
  localparam logic [2:0] MODE_PHYS     = 3'd0;
  localparam logic [2:0] MODE_USER_PRI = 3'd1;
  localparam logic [2:0] MODE_KERN_PRI = 3'd2;
  localparam logic [2:0] MODE_USER_SEC = 3'd3;
  localparam logic [2:0] MODE_KERN_SEC = 3'd4;
  localparam logic [2:0] MODE_NUCLEUS  = 3'd5;

  // Fixed field positions of the status word
  localparam int BIT_VALID = 0;
  localparam int BIT_OVF   = 1;
  localparam int BIT_CTX   = 2;
  localparam int BIT_WRITE = 4;
  localparam int BIT_NF    = 5;
  localparam int BIT_PRIV  = 6;
  localparam int BIT_MIS   = 7;
  localparam int BIT_CAUSE = 8;

  typedef enum logic [1:0] {
    CTX_NONE = 2'b00,
    CTX_PRI  = 2'b01,
    CTX_SEC  = 2'b10,
    CTX_NUC  = 2'b11
  } ctx_type_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic clearFlags;
    logic markOverflow;
    logic mergeCause;
  } mfc_strobe_t;

  function automatic ctx_type_e ctxOf(input logic [2:0] mode,
                                      input logic [1:0] acc,
                                      input logic tlNz);
    ctx_type_e c;
    case (mode)
      MODE_USER_PRI, MODE_KERN_PRI: c = CTX_PRI;
      MODE_USER_SEC, MODE_KERN_SEC: c = CTX_SEC;
      MODE_NUCLEUS:                 c = CTX_NUC;
      default:                      c = CTX_NONE;
    endcase
    if (acc == ACC_FETCH && tlNz) c = CTX_NUC;
    return c;
  endfunction

endpackage

// File: rtl/mfc_ctrl.sv
module mfc_ctrl
  import mfc_pkg::*;
(
  input  logic        faultStb,
  input  logic        misalignStb,
  input  logic        statusRd,
  input  logic        validQ,
  output mfc_strobe_t strobe
);

  logic anyFault;
  logic unreadPrev;

  assign anyFault   = faultStb | misalignStb;
  // Previous record still unseen by software and not being read now
  assign unreadPrev = validQ & ~statusRd;

  always_comb begin
    strobe              = '0;
    strobe.capture      = anyFault;
    strobe.clearFlags   = statusRd & ~anyFault;
    strobe.markOverflow = anyFault & unreadPrev;
    strobe.mergeCause   = anyFault & unreadPrev;
  end

endmodule

// File: rtl/mfc_datapath.sv
module mfc_datapath
  import mfc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int FT_W   = 4,
  localparam int SW    = BIT_CAUSE + FT_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  mfc_strobe_t       strobe,
  input  logic              faultStb,
  input  logic              misalignStb,
  input  logic [2:0]        xlatMode,
  input  logic [1:0]        accType,
  input  logic              privState,
  input  logic              trapLevelNz,
  input  logic [FT_W-1:0]   faultBits,
  input  logic [ADDR_W-1:0] faultAddrIn,
  output logic [SW-1:0]     statusWord,
  output logic [ADDR_W-1:0] faultAddr,
  output logic              validQ
);

  logic              ovfQ, wrQ, nfQ, privQ, misQ;
  ctx_type_e         ctxQ;
  logic [FT_W-1:0]   causeQ;
  logic [ADDR_W-1:0] addrQ;

  logic [FT_W-1:0]   newCause;
  logic              newMis;

  assign newCause = faultStb ? faultBits : '0;
  assign newMis   = misalignStb;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
      ovfQ   <= 1'b0;
      wrQ    <= 1'b0;
      nfQ    <= 1'b0;
      privQ  <= 1'b0;
      misQ   <= 1'b0;
      ctxQ   <= CTX_NONE;
      causeQ <= '0;
      addrQ  <= '0;
    end else if (strobe.capture) begin
      validQ <= 1'b1;
      ovfQ   <= strobe.markOverflow;
      wrQ    <= (accType == ACC_STORE);
      nfQ    <= (accType == ACC_NFLD);
      privQ  <= privState;
      ctxQ   <= ctxOf(xlatMode, accType, trapLevelNz);
      addrQ  <= faultAddrIn;
      if (strobe.mergeCause) begin
        causeQ <= causeQ | newCause;
        misQ   <= misQ | newMis;
      end else begin
        causeQ <= newCause;
        misQ   <= newMis;
      end
    end else if (strobe.clearFlags) begin
      validQ <= 1'b0;
      ovfQ   <= 1'b0;
    end
  end

  always_comb begin
    statusWord                     = '0;
    statusWord[BIT_VALID]          = validQ;
    statusWord[BIT_OVF]            = ovfQ;
    statusWord[BIT_CTX +: 2]       = ctxQ;
    statusWord[BIT_WRITE]          = wrQ;
    statusWord[BIT_NF]             = nfQ;
    statusWord[BIT_PRIV]           = privQ;
    statusWord[BIT_MIS]            = misQ;
    statusWord[BIT_CAUSE +: FT_W]  = causeQ;
  end

  assign faultAddr = addrQ;

endmodule

// File: rtl/mmu_fault_capture.sv
module mmu_fault_capture
  import mfc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int FT_W   = 4,
  localparam int SW    = BIT_CAUSE + FT_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              faultStb,
  input  logic              misalignStb,
  input  logic              statusRd,
  input  logic [2:0]        xlatMode,
  input  logic [1:0]        accType,
  input  logic              privState,
  input  logic              trapLevelNz,
  input  logic [FT_W-1:0]   faultBits,
  input  logic [ADDR_W-1:0] faultAddrIn,
  output logic [SW-1:0]     statusWord,
  output logic [ADDR_W-1:0] faultAddr
);

  mfc_strobe_t strobe;
  logic        validQ;

  mfc_ctrl u_ctrl (
    .faultStb    (faultStb),
    .misalignStb (misalignStb),
    .statusRd    (statusRd),
    .validQ      (validQ),
    .strobe      (strobe)
  );

  mfc_datapath #(.ADDR_W(ADDR_W), .FT_W(FT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .faultStb    (faultStb),
    .misalignStb (misalignStb),
    .xlatMode    (xlatMode),
    .accType     (accType),
    .privState   (privState),
    .trapLevelNz (trapLevelNz),
    .faultBits   (faultBits),
    .faultAddrIn (faultAddrIn),
    .statusWord  (statusWord),
    .faultAddr   (faultAddr),
    .validQ      (validQ)
  );

endmodule

// File: rtl/mmu_fault_capture_chk.sv
module mmu_fault_capture_chk
  import mfc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int FT_W   = 4,
  localparam int SW    = BIT_CAUSE + FT_W
)(
  input logic              clk,
  input logic              rstN,
  input logic              faultStb,
  input logic              misalignStb,
  input logic              statusRd,
  input logic [1:0]        accType,
  input logic              privState,
  input logic              trapLevelNz,
  input logic [ADDR_W-1:0] faultAddrIn,
  input logic [SW-1:0]     statusWord,
  input logic [ADDR_W-1:0] faultAddr
);

  logic cap;
  assign cap = faultStb | misalignStb;

  p_valid_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    cap |=> statusWord[BIT_VALID]);

  p_addr_capture_r2: assert property (@(posedge clk) disable iff (!rstN)
    cap |=> faultAddr == $past(faultAddrIn));

  p_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cap && statusWord[BIT_VALID] && !statusRd) |=> statusWord[BIT_OVF]);

  p_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !cap) |=> !statusWord[BIT_VALID] && !statusWord[BIT_OVF]);

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cap && statusRd) |=> statusWord[BIT_VALID] && !statusWord[BIT_OVF]);

  p_fetch_nucleus_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cap && accType == ACC_FETCH && trapLevelNz) |=> statusWord[BIT_CTX +: 2] == 2'b11);

  p_write_bit_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cap && accType == ACC_STORE) |=> statusWord[BIT_WRITE] && !statusWord[BIT_NF]);

  p_priv_r9: assert property (@(posedge clk) disable iff (!rstN)
    cap |=> statusWord[BIT_PRIV] == $past(privState));

  p_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!cap && !statusRd) |=> $stable(statusWord) && $stable(faultAddr));

  p_ovf_needs_valid_r3: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[BIT_OVF] |-> statusWord[BIT_VALID]);

endmodule

bind mmu_fault_capture mmu_fault_capture_chk #(.ADDR_W(ADDR_W), .FT_W(FT_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .faultStb    (faultStb),
  .misalignStb (misalignStb),
  .statusRd    (statusRd),
  .accType     (accType),
  .privState   (privState),
  .trapLevelNz (trapLevelNz),
  .faultAddrIn (faultAddrIn),
  .statusWord  (statusWord),
  .faultAddr   (faultAddr)
);

// File: tb/test_mmu_fault_capture.sv
module test_mmu_fault_capture;

  localparam int ADDR_W = 32;
  localparam int FT_W   = 4;
  localparam int SW     = 8 + FT_W;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rstN;
  logic              faultStb, misalignStb, statusRd;
  logic [2:0]        xlatMode;
  logic [1:0]        accType;
  logic              privState, trapLevelNz;
  logic [FT_W-1:0]   faultBits;
  logic [ADDR_W-1:0] faultAddrIn;
  logic [SW-1:0]     statusWord;
  logic [ADDR_W-1:0] faultAddr;

  int nChecks = 0;
  int nFails  = 0;

  // Reference model state
  logic              mValid, mOvf, mWr, mNf, mPriv, mMis;
  logic [1:0]        mCtx;
  logic [FT_W-1:0]   mCause;
  logic [ADDR_W-1:0] mAddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmu_fault_capture #(.ADDR_W(ADDR_W), .FT_W(FT_W)) i_mmu_fault_capture (
    .clk(clk), .rstN(rstN), .faultStb(faultStb), .misalignStb(misalignStb),
    .statusRd(statusRd), .xlatMode(xlatMode), .accType(accType),
    .privState(privState), .trapLevelNz(trapLevelNz), .faultBits(faultBits),
    .faultAddrIn(faultAddrIn), .statusWord(statusWord), .faultAddr(faultAddr)
  );

  function automatic logic [1:0] expCtx(input logic [2:0] m, input logic [1:0] a,
                                        input logic tl);
    logic [1:0] c;
    case (m)
      3'd1, 3'd2: c = 2'b01;
      3'd3, 3'd4: c = 2'b10;
      3'd5:       c = 2'b11;
      default:    c = 2'b00;
    endcase
    if (a == 2'd3 && tl) c = 2'b11;
    return c;
  endfunction

  function automatic logic [SW-1:0] expWord();
    return {mCause, mMis, mPriv, mNf, mWr, mCtx, mOvf, mValid};
  endfunction

  task automatic modelStep();
    logic cap, merge;
    cap   = faultStb | misalignStb;
    merge = mValid & ~statusRd;
    if (cap) begin
      mOvf   = merge;
      mValid = 1'b1;
      mWr    = (accType == 2'd1);
      mNf    = (accType == 2'd2);
      mPriv  = privState;
      mCtx   = expCtx(xlatMode, accType, trapLevelNz);
      mAddr  = faultAddrIn;
      if (merge) begin
        mCause = mCause | (faultStb ? faultBits : '0);
        mMis   = mMis | misalignStb;
      end else begin
        mCause = faultStb ? faultBits : '0;
        mMis   = misalignStb;
      end
    end else if (statusRd) begin
      mValid = 1'b0;
      mOvf   = 1'b0;
    end
  endtask

  task automatic compare(input string req);
    nChecks++;
    if (statusWord !== expWord() || faultAddr !== mAddr) begin
      nFails++;
      $display("FAIL %s: status=%h addr=%h expected status=%h addr=%h",
               req, statusWord, faultAddr, expWord(), mAddr);
    end
  endtask

  task automatic applyVec(input logic fs, input logic ms, input logic rd,
                          input logic [2:0] md, input logic [1:0] ac,
                          input logic pv, input logic tl,
                          input logic [FT_W-1:0] fb, input logic [ADDR_W-1:0] ad,
                          input string req);
    @(negedge clk);
    faultStb = fs; misalignStb = ms; statusRd = rd; xlatMode = md;
    accType = ac; privState = pv; trapLevelNz = tl; faultBits = fb; faultAddrIn = ad;
    modelStep();
    @(posedge clk);
    #1;
    compare(req);
  endtask

  task automatic idle(input string req);
    applyVec(1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0, 1'b0, '0, '0, req);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    rstN = 1'b0;
    faultStb = 0; misalignStb = 0; statusRd = 0; xlatMode = 0; accType = 0;
    privState = 0; trapLevelNz = 0; faultBits = 0; faultAddrIn = 0;
    mValid = 0; mOvf = 0; mWr = 0; mNf = 0; mPriv = 0; mMis = 0;
    mCtx = 0; mCause = 0; mAddr = 0;
    repeat (3) @(posedge clk);
    #1;
    compare("R1 reset");
    @(negedge clk);
    rstN = 1'b1;

    // Directed: first fault, store, privileged, primary mode
    applyVec(1, 0, 0, 3'd2, 2'd1, 1, 0, 4'b0010, 32'hCAFE_1000, "R2 R8 R9 first capture");
    idle("R12 hold");
    // Second fault before read: overflow and merge
    applyVec(1, 0, 0, 3'd3, 2'd2, 0, 0, 4'b0100, 32'hCAFE_2000, "R3 R10 overflow merge");
    // Read clears flags only
    applyVec(0, 0, 1, 3'd0, 2'd0, 0, 0, 4'b1111, 32'h0, "R4 read clears flags");
    // Capture after read replaces causes
    applyVec(1, 0, 0, 3'd5, 2'd0, 0, 0, 4'b0001, 32'hCAFE_3000, "R10 replace after read");
    // Capture with coincident read
    applyVec(1, 0, 1, 3'd1, 2'd3, 1, 0, 4'b1000, 32'hCAFE_4000, "R5 capture wins read");
    // Fetch at raised trap level in untranslated mode
    applyVec(0, 0, 1, 3'd0, 2'd0, 0, 0, '0, '0, "R4 read");
    applyVec(1, 0, 0, 3'd0, 2'd3, 0, 1, 4'b0011, 32'hCAFE_5000, "R7 fetch nucleus");
    applyVec(0, 0, 1, 3'd0, 2'd0, 0, 0, '0, '0, "R4 read");
    // Misaligned alone
    applyVec(0, 1, 0, 3'd4, 2'd0, 0, 0, 4'b1111, 32'hCAFE_6003, "R11 misaligned");
    applyVec(0, 0, 1, 3'd0, 2'd0, 0, 0, '0, '0, "R4 read");
    // Every mode code
    for (int m = 0; m < 8; m++) begin
      applyVec(1, 0, 1, m[2:0], 2'd0, 0, 1, 4'b0001, 32'h1000 * m, "R6 context encoding");
    end
    // Store with fault in reserved mode
    applyVec(1, 0, 1, 3'd7, 2'd1, 0, 0, 4'b0101, 32'hDEAD_0000, "R6 R8 reserved mode");

    // Random
    for (int i = 0; i < 3000; i++) begin
      logic [ADDR_W-1:0] ra;
      logic [FT_W-1:0]   rb;
      logic [31:0]       r;
      r  = $urandom;
      ra = $urandom;
      rb = FT_W'($urandom);
      applyVec(r[2:0] == 3'd0, r[5:3] == 3'd0, r[8:6] < 3'd2, r[11:9], r[13:12],
               r[14], r[15], rb, ra, "R2 R3 R4 R5 R10 R12 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule